// File: doc/BRIEF.md
# Inter-Processor Interrupt Send Decoder

This block turns a 32-bit interrupt send command into a set request for one core's interrupt status bank. A command word carries a target core number and a 5-bit interrupt vector; the block converts the vector into a one-hot 32-bit status mask and raises a single-cycle strobe toward the addressed core. The status bank ORs that mask into its pending bits.

The core number maps directly to a core index: number n selects core n. A command whose core number is at or above the configured core count is refused. In that case the block pulses an error flag and strobes no core. The core count is a parameter and must be at least 1.

Commands arrive over a valid/ready handshake. The block has no back-pressure: `cmd_ready` is high at all times outside reset, so a command transfers on every rising edge where `cmd_valid` is high. The results appear on the registered outputs one cycle later, and each result lasts exactly one cycle.

Top module: `ipi_send_decoder`

## Requirements
- R1: `cmd_ready` is 1 whenever reset is released, so a command is accepted on every rising edge where `cmd_valid` is 1.
- R2: The target core number is `cmd_data[25:16]`. When that number n is below `NUM_CORES`, `set_stb` equals `1 << n` in the cycle after acceptance, and in that cycle only.
- R3: The vector is `cmd_data[4:0]`. Whenever a strobe is issued, `set_mask` equals `32'd1 << vector` in the same cycle.
- R4: When the core number is at or above `NUM_CORES`, `dec_err` is 1 for one cycle after acceptance, while `set_stb` and `set_mask` stay 0.
- R5: At most one bit of `set_stb` is ever 1. An error and a strobe never occur together.
- R6: The bits `cmd_data[31:26]` and `cmd_data[15:5]` have no effect on any output.
- R7: In a cycle that follows no accepted command, `set_stb`, `set_mask` and `dec_err` are all 0.
- R8: While `rst_n` is low, and in the first cycle after it rises, all outputs are 0, including `cmd_ready` while reset is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Send command present |
| cmd_ready | output | 1 | Command accepted (constant 1 out of reset) |
| cmd_data | input | 32 | Send command word |
| set_stb | output | NUM_CORES | One-hot per-core set request strobe |
| set_mask | output | 32 | One-hot status bit to set |
| dec_err | output | 1 | Target core does not exist |

## Verification
The bench goes after the core-number boundary: numbers `NUM_CORES-1`, `NUM_CORES` and 1023. A wrong comparison would either strobe a core that does not exist or refuse the last real core. Vectors 0 and 31 exercise the ends of the one-hot decoder, where an off-by-one shift would drop or wrap the mask bit. Commands with every ignored bit set catch a decoder that slices the wrong field. Back-to-back commands, interleaved with idle cycles, expose strobes that are held for more than one cycle or that leak into an idle cycle.

// File: rtl/ipi_send_pkg.sv
package ipi_send_pkg;
  localparam int CMD_W   = 32;
  localparam int ID_LSB  = 16;
  localparam int ID_W    = 10;
  localparam int VEC_LSB = 0;
  localparam int VEC_W   = 5;
  localparam int MASK_W  = 1 << VEC_W;

  typedef struct packed {
    logic [ID_W-1:0]  core_id;
    logic [VEC_W-1:0] vec;
  } ipi_fields_t;
endpackage

// File: rtl/ipi_cmd_fields.sv
module ipi_cmd_fields
  import ipi_send_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic [CMD_W-1:0] cmd,
  output ipi_fields_t      fields,
  output logic             in_range
);
  localparam logic [ID_W:0] CORE_LIMIT = (ID_W+1)'(NUM_CORES);

  // Bits outside the two decoded fields are deliberately discarded (R6).
  logic unused_cmd_bits;
  assign unused_cmd_bits = ^{cmd[CMD_W-1:ID_LSB+ID_W], cmd[ID_LSB-1:VEC_LSB+VEC_W]};

  always_comb begin
    fields.core_id = cmd[ID_LSB +: ID_W];
    fields.vec     = cmd[VEC_LSB +: VEC_W];
    in_range       = ({1'b0, fields.core_id} < CORE_LIMIT);
  end
endmodule

// File: rtl/ipi_vec_onehot.sv
module ipi_vec_onehot
  import ipi_send_pkg::*;
(
  input  logic [VEC_W-1:0]  vec,
  output logic [MASK_W-1:0] onehot
);
  for (genvar b = 0; b < MASK_W; b++) begin : g_bit
    assign onehot[b] = (vec == VEC_W'(b));
  end

  always_comb begin
    a_r3_decoder_onehot: assert ($countones(onehot) == 1);
  end
endmodule

// File: rtl/ipi_core_strobe.sv
module ipi_core_strobe
  import ipi_send_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic [ID_W-1:0]      core_id,
  output logic [NUM_CORES-1:0] stb
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb[c] <= 1'b0;
      else        stb[c] <= fire && (core_id == ID_W'(c));
    end

    // R2: a strobe on core c comes from an accepted command addressed to c
    a_r2_target_match: assert property (@(posedge clk) disable iff (!rst_n)
      stb[c] |-> ($past(fire) && $past(core_id) == ID_W'(c)));
  end

  // R5: never more than one core strobed
  a_r5_single_core: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));
endmodule

// File: rtl/ipi_send_decoder.sv
module ipi_send_decoder
  import ipi_send_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [31:0]          cmd_data,
  output logic [NUM_CORES-1:0] set_stb,
  output logic [31:0]          set_mask,
  output logic                 dec_err
);
  ipi_fields_t        fields;
  logic               in_range;
  logic [MASK_W-1:0]  vec_onehot;
  logic               accept;
  logic               fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_ready <= 1'b0;
    else        cmd_ready <= 1'b1;
  end

  assign accept = cmd_valid && cmd_ready;
  assign fire   = accept && in_range;

  ipi_cmd_fields #(.NUM_CORES(NUM_CORES)) u_fields (
    .cmd      (cmd_data),
    .fields   (fields),
    .in_range (in_range)
  );

  ipi_vec_onehot u_onehot (
    .vec    (fields.vec),
    .onehot (vec_onehot)
  );

  ipi_core_strobe #(.NUM_CORES(NUM_CORES)) u_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .core_id (fields.core_id),
    .stb     (set_stb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_mask <= '0;
      dec_err  <= 1'b0;
    end else begin
      set_mask <= fire ? vec_onehot : '0;
      dec_err  <= accept && !in_range;
    end
  end

  // R3: mask is a single bit whenever a core is strobed
  a_r3_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_stb) |-> ($countones(set_mask) == 1));

  // R3: the set bit is the accepted vector
  a_r3_mask_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_stb) |-> (set_mask == (32'd1 << $past(cmd_data[4:0]))));

  // R4 / R5: a refused command touches no core
  a_r4_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> (set_stb == '0 && set_mask == '0));

  // R7: results only follow an accepted command
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_stb || dec_err || |set_mask) |-> $past(cmd_valid));

  // R1: ready stays high once out of reset
  a_r1_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |=> cmd_ready);
endmodule

// File: tb/test_ipi_send_decoder.sv
module test_ipi_send_decoder;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [31:0]   cmd_data = '0;
  logic [NC-1:0] set_stb;
  logic [31:0]   set_mask;
  logic          dec_err;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  ipi_send_decoder #(.NUM_CORES(NC)) i_ipi_send_decoder (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_data, .set_stb, .set_mask, .dec_err
  );

  function automatic logic [NC-1:0] exp_stb(bit v, logic [31:0] c);
    int id = int'(c[25:16]);
    if (v && id < NC) return NC'(1) << id;
    return '0;
  endfunction

  function automatic logic [31:0] exp_mask(bit v, logic [31:0] c);
    if (v && int'(c[25:16]) < NC) return 32'd1 << c[4:0];
    return '0;
  endfunction

  function automatic bit exp_err(bit v, logic [31:0] c);
    return v && int'(c[25:16]) >= NC;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at falling edge, results registered at next rising edge, sample at following fall
  task automatic step(bit v, logic [31:0] c, string req);
    cmd_valid = v;
    cmd_data  = c;
    @(posedge clk);
    @(negedge clk);
    check({req, " R1 ready"}, 64'(cmd_ready), 64'(1'b1));
    check({req, " R2 stb"},   64'(set_stb),   64'(exp_stb(v, c)));
    check({req, " R3 mask"},  64'(set_mask),  64'(exp_mask(v, c)));
    check({req, " R4 err"},   64'(dec_err),   64'(exp_err(v, c)));
    check({req, " R5 onehot0"}, 64'($countones(set_stb) <= 1 && !(dec_err && |set_stb)), 64'(1));
  endtask

  function automatic logic [31:0] mk(int id, int vec, logic [31:0] junk);
    logic [31:0] c = junk & 32'hFC00_FFE0;
    c[25:16] = 10'(id);
    c[4:0]   = 5'(vec);
    return c;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    @(negedge clk);
    check("R8 reset ready", 64'(cmd_ready), 64'(0));
    check("R8 reset stb",   64'(set_stb),   64'(0));
    check("R8 reset mask",  64'(set_mask),  64'(0));
    check("R8 reset err",   64'(dec_err),   64'(0));
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8 first cycle stb", 64'(set_stb), 64'(0));

    // directed corners
    step(1'b1, mk(0, 0, '0),            "corner id0 vec0");
    step(1'b1, mk(NC-1, 31, '0),        "corner last core vec31");
    step(1'b1, mk(NC, 7, '0),           "corner id=NC");
    step(1'b1, mk(1023, 3, '0),         "corner id max");
    step(1'b1, mk(1, 9, 32'hFFFF_FFFF), "R6 junk bits set");
    step(1'b0, mk(2, 4, '0),            "R7 idle");
    step(1'b1, mk(2, 17, 32'hA5A5_5A5A), "R6 junk pattern");
    step(1'b0, 32'hFFFF_FFFF,           "R7 idle junk");

    // constrained random, mixes back-to-back and idle cycles
    for (int i = 0; i < 600; i++) begin
      int sel = int'($urandom_range(0, 9));
      int id;
      if (sel < 6)       id = int'($urandom_range(0, NC-1));
      else if (sel < 8)  id = int'($urandom_range(NC, 1023));
      else               id = (sel == 8) ? NC-1 : NC;
      step(($urandom_range(0, 4) != 0), mk(id, int'($urandom_range(0, 31)), $urandom()), "random");
    end

    step(1'b0, '0, "R7 final idle");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule